// File: doc/BRIEF.md
# Byte-Serial AES-128 Encryption Core

This core encrypts one 128-bit block under a 128-bit key. All arithmetic runs through an 8-bit datapath. A phase sequencer walks a 32-byte working store. The lower 16 bytes hold the cipher state and the upper 16 bytes hold the current round key. Each round key is derived from the previous one in place, so the store only ever contains the key for the round in progress. The datapath holds a pipelined substitution unit, a column mixer and a bytewise XOR for key addition. The row rotation step has no logic of its own. The sequencer applies it by choosing which addresses it reads and writes while it substitutes a row.

In use, software-side logic writes the plaintext and key through the load port while the core is idle. It then pulses `start` and waits for the one-cycle `done` pulse. After that pulse it reads the ciphertext bytes through the read port. The whole encryption takes a fixed number of cycles. Load writes and start pulses that arrive while the core is busy are dropped.

Top module: `aes_byte_core`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every state byte returned on `rd_data` is 0x00.
- R2: While idle, a load write with `ld_we`=1 stores `ld_data` at `ld_addr`. Addresses 0..15 hold plaintext byte 0..15 and addresses 16..31 hold key byte 0..15. Byte 0 is the most significant byte of the 128-bit value as written in hex.
- R3: A `start` pulse sampled while idle makes `busy` high from the next cycle. `busy` stays high until the cycle that `done` rises. A `start` that arrives while busy is ignored.
- R4: After `done`, reading `rd_addr`=i returns ciphertext byte i of AES-128 encryption with 10 rounds. The last round omits column mixing. For key 000102..0f and plaintext 00112233..ff the result is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R5: `done` is high for exactly one cycle, with `busy` low in that cycle. It rises on the 1035th rising edge, counting the edge that samples `start` as the first.
- R6: Load-port writes made while busy change neither the ciphertext nor the timing of `done`.
- R7: `rd_data` shows state byte `rd_addr` combinationally. Before `start` it returns the loaded plaintext.
- R8: The substitution maps byte 0x00 to 0x63, so an all-zero key and plaintext give 66e94bd4ef8a2c3b884cfa59ca342b2e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Load write enable |
| ld_addr | input | 5 | Load address: 0..15 plaintext, 16..31 key |
| ld_data | input | 8 | Load data byte |
| start | input | 1 | Start pulse, honoured only while idle |
| rd_addr | input | 4 | State byte select for reading |
| rd_data | output | 8 | Selected state byte |
| busy | output | 1 | Encryption in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can fall in the same cycle. The first is a load-port write or start pulse from outside. The second is one of the core's own in-place writes to the same 32-byte store. The bench provokes this collision by driving random addresses, data and start pulses on every busy cycle of several encryptions. Encryptions run with this noise and without it. A collision is judged handled when the ciphertext still matches an independently computed reference, `done` still arrives on the 1035th edge, and the core does not restart afterwards.

// File: rtl/aes_byte_pkg.sv
package aes_byte_pkg;
    localparam int unsigned BW = 8;               // datapath byte width
    localparam int unsigned NB = 16;              // bytes per block / key
    localparam int unsigned AW = $clog2(2 * NB);  // working store address width
    localparam int unsigned SAW = $clog2(NB);     // state byte address width

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ARK  = 3'd1,
        PH_SUB  = 3'd2,
        PH_MIX  = 3'd3,
        PH_KEY  = 3'd4
    } phase_e;

    function automatic logic [BW-1:0] gf_x2(input logic [BW-1:0] a);
        return {a[BW-2:0], 1'b0} ^ (a[BW-1] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [BW-1:0] gf_mul(input logic [BW-1:0] a, input logic [BW-1:0] b);
        logic [BW-1:0] acc;
        logic [BW-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BW; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_x2(sh);
        end
        return acc;
    endfunction
endpackage

// File: rtl/aes_sbox_pipe.sv
module aes_sbox_pipe
    import aes_byte_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] in_byte,
    output logic [BW-1:0] out_byte
);
    logic [BW-1:0] inv, aff, out_d, out_q;
    logic [BW-1:0] p2, p3, p6, p7, p14, p15, p30, p31, p62, p63, p126, p127;

    // inverse as a^254; zero maps to zero by itself
    always_comb begin
        p2   = gf_mul(in_byte, in_byte);
        p3   = gf_mul(p2, in_byte);
        p6   = gf_mul(p3, p3);
        p7   = gf_mul(p6, in_byte);
        p14  = gf_mul(p7, p7);
        p15  = gf_mul(p14, in_byte);
        p30  = gf_mul(p15, p15);
        p31  = gf_mul(p30, in_byte);
        p62  = gf_mul(p31, p31);
        p63  = gf_mul(p62, in_byte);
        p126 = gf_mul(p63, p63);
        p127 = gf_mul(p126, in_byte);
        inv  = gf_mul(p127, p127);
        aff  = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                   ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
        out_d = aff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_byte = out_q;

    // R8
    sbox_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(in_byte) == 8'h00)) |-> (out_byte == 8'h63));
endmodule

// File: rtl/aes_col_mixer.sv
module aes_col_mixer
    import aes_byte_pkg::*;
(
    input  logic [3:0][BW-1:0] col,
    input  logic [1:0]         sel,
    output logic [BW-1:0]      out_byte
);
    logic [1:0] i1, i2, i3;

    always_comb begin
        i1 = sel + 2'd1;
        i2 = sel + 2'd2;
        i3 = sel + 2'd3;
        out_byte = gf_x2(col[sel]) ^ gf_x2(col[i1]) ^ col[i1] ^ col[i2] ^ col[i3];
    end

    // R4
    always_comb begin
        if ((col[0] == col[1]) && (col[1] == col[2]) && (col[2] == col[3])) begin
            mix_uniform_chk: assert (out_byte == col[0]);
        end
    end
endmodule

// File: rtl/aes_byte_core.sv
module aes_byte_core
    import aes_byte_pkg::*;
#(
    parameter int unsigned ROUNDS = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_we,
    input  logic [AW-1:0]  ld_addr,
    input  logic [BW-1:0]  ld_data,
    input  logic           start,
    input  logic [SAW-1:0] rd_addr,
    output logic [BW-1:0]  rd_data,
    output logic           busy,
    output logic           done
);
    localparam int unsigned RW = $clog2(ROUNDS + 1);
    localparam int unsigned SW = 5;
    localparam logic [AW-1:0] KBASE = AW'(NB);
    localparam logic [AW-1:0] KWORD1 = AW'(NB + 4);
    localparam logic [AW-1:0] KLAST = AW'(2 * NB - 4);

    typedef struct packed {
        phase_e                   ph;
        logic [1:0]               grp;
        logic [SW-1:0]            stp;
        logic [RW-1:0]            rnd;
        logic [BW-1:0]            rcon;
        logic [3:0][BW-1:0]       tmp;
        logic                     done;
        logic [2*NB-1:0][BW-1:0]  mem;
    } core_st_t;

    core_st_t      st_d, st_q;
    logic [BW-1:0] sb_in, sb_q, mix_b;
    logic [1:0]    wsel;
    logic [AW-1:0] kj, sa;

    aes_sbox_pipe u_sbox (.clk(clk), .rst_n(rst_n), .in_byte(sb_in), .out_byte(sb_q));
    aes_col_mixer u_mix  (.col(st_q.tmp), .sel(st_q.stp[1:0]), .out_byte(mix_b));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        sb_in     = '0;
        wsel      = st_q.stp[1:0] - 2'd1;
        kj        = AW'(st_q.stp - SW'(9));
        sa        = '0;
        case (st_q.ph)
            PH_IDLE: begin
                if (ld_we) st_d.mem[ld_addr] = ld_data;
                if (start) begin
                    st_d.ph   = PH_ARK;
                    st_d.stp  = '0;
                    st_d.rnd  = '0;
                    st_d.rcon = 8'h01;
                end
            end
            PH_ARK: begin
                sa = AW'(st_q.stp[3:0]);
                st_d.mem[sa] = st_q.mem[sa] ^ st_q.mem[KBASE + sa];
                st_d.stp = st_q.stp + SW'(1);
                if (st_q.stp == SW'(NB - 1)) begin
                    st_d.stp = '0;
                    st_d.grp = '0;
                    if (st_q.rnd == RW'(ROUNDS)) begin
                        st_d.ph   = PH_IDLE;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.rnd = st_q.rnd + RW'(1);
                        st_d.ph  = PH_SUB;
                    end
                end
            end
            PH_SUB: begin
                // grp is the row; reads gather it, writes place it rotated
                if (st_q.stp < SW'(4)) begin
                    st_d.tmp[st_q.stp[1:0]] = st_q.mem[AW'({st_q.stp[1:0], st_q.grp})];
                end else if (st_q.stp < SW'(8)) begin
                    sb_in = st_q.tmp[st_q.stp[1:0] + st_q.grp];
                end
                if (st_q.stp >= SW'(5)) begin
                    st_d.mem[AW'({wsel, st_q.grp})] = sb_q;
                end
                st_d.stp = st_q.stp + SW'(1);
                if (st_q.stp == SW'(8)) begin
                    st_d.stp = '0;
                    st_d.grp = st_q.grp + 2'd1;
                    if (st_q.grp == 2'd3) begin
                        st_d.ph = (st_q.rnd == RW'(ROUNDS)) ? PH_KEY : PH_MIX;
                    end
                end
            end
            PH_MIX: begin
                // grp is the column
                if (st_q.stp < SW'(4)) begin
                    st_d.tmp[st_q.stp[1:0]] = st_q.mem[AW'({st_q.grp, st_q.stp[1:0]})];
                end else begin
                    st_d.mem[AW'({st_q.grp, st_q.stp[1:0]})] = mix_b;
                end
                st_d.stp = st_q.stp + SW'(1);
                if (st_q.stp == SW'(7)) begin
                    st_d.stp = '0;
                    st_d.grp = st_q.grp + 2'd1;
                    if (st_q.grp == 2'd3) st_d.ph = PH_KEY;
                end
            end
            PH_KEY: begin
                if (st_q.stp < SW'(4)) begin
                    st_d.tmp[st_q.stp[1:0]] = st_q.mem[KLAST + AW'(st_q.stp[1:0])];
                end else if (st_q.stp < SW'(8)) begin
                    sb_in = st_q.tmp[st_q.stp[1:0] + 2'd1];
                end
                if ((st_q.stp >= SW'(5)) && (st_q.stp <= SW'(8))) begin
                    st_d.mem[KBASE + AW'(wsel)] = st_q.mem[KBASE + AW'(wsel)] ^ sb_q
                                                ^ ((wsel == 2'd0) ? st_q.rcon : 8'h00);
                end else if (st_q.stp >= SW'(9)) begin
                    st_d.mem[KWORD1 + kj] = st_q.mem[KWORD1 + kj] ^ st_q.mem[KBASE + kj];
                end
                st_d.stp = st_q.stp + SW'(1);
                if (st_q.stp == SW'(20)) begin
                    st_d.stp  = '0;
                    st_d.rcon = gf_x2(st_q.rcon);
                    st_d.ph   = PH_ARK;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.mem[AW'(rd_addr)];
    assign busy    = (st_q.ph != PH_IDLE);
    assign done    = st_q.done;

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R2
    load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we && !busy) |=> (st_q.mem[$past(ld_addr)] == $past(ld_data)));
    // R3
    rnd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rnd <= RW'(ROUNDS));
endmodule

// File: tb/aes_byte_core_bench.sv
`timescale 1ns/1ps
module aes_byte_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_we = 1'b0;
    logic [4:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic       start = 1'b0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy, done;
    int         total = 0;
    int         bad = 0;
    bit         ended = 1'b0;
    logic [7:0] sb_tab [256];

    always #2.5 clk = ~clk;

    aes_byte_core u_aes_byte_core (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .start(start), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
    );

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        logic [7:0] y = b;
        for (int i = 0; i < 8; i++) begin
            if (y[0]) p = p ^ x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
            y = y >> 1;
        end
        return p;
    endfunction

    function automatic logic [7:0] m_sub(input logic [7:0] a);
        logic [7:0] iv = 8'h00;
        logic [7:0] r = 8'h63;
        for (int y = 1; y < 256; y++) if (m_mul(a, y[7:0]) == 8'h01) iv = y[7:0];
        for (int i = 0; i < 8; i++)
            r[i] = r[i] ^ iv[i] ^ iv[(i + 4) % 8] ^ iv[(i + 5) % 8] ^ iv[(i + 6) % 8] ^ iv[(i + 7) % 8];
        return r;
    endfunction

    function automatic logic [127:0] aes_ref(input logic [127:0] pt, input logic [127:0] key);
        logic [7:0] s [16];
        logic [7:0] k [16];
        logic [7:0] t [16];
        logic [7:0] w [4];
        logic [7:0] rc = 8'h01;
        logic [127:0] res;
        for (int i = 0; i < 16; i++) begin
            s[i] = pt[127 - 8 * i -: 8];
            k[i] = key[127 - 8 * i -: 8];
            s[i] = s[i] ^ k[i];
        end
        for (int rn = 1; rn <= 10; rn++) begin
            for (int i = 0; i < 16; i++) t[i] = sb_tab[s[i]];
            for (int c = 0; c < 4; c++)
                for (int q = 0; q < 4; q++) s[c * 4 + q] = t[((c + q) % 4) * 4 + q];
            if (rn != 10) begin
                for (int c = 0; c < 4; c++) begin
                    for (int q = 0; q < 4; q++) t[q] = s[c * 4 + q];
                    for (int q = 0; q < 4; q++)
                        s[c * 4 + q] = m_mul(t[q], 8'h02) ^ m_mul(t[(q + 1) % 4], 8'h03)
                                     ^ t[(q + 2) % 4] ^ t[(q + 3) % 4];
                end
            end
            w[0] = sb_tab[k[13]] ^ rc;
            w[1] = sb_tab[k[14]];
            w[2] = sb_tab[k[15]];
            w[3] = sb_tab[k[12]];
            for (int q = 0; q < 4; q++) k[q] = k[q] ^ w[q];
            for (int i = 4; i < 16; i++) k[i] = k[i] ^ k[i - 4];
            rc = m_mul(rc, 8'h02);
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ k[i];
        end
        for (int i = 0; i < 16; i++) res[127 - 8 * i -: 8] = s[i];
        return res;
    endfunction

    task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic read_state(output logic [127:0] v);
        for (int i = 0; i < 16; i++) begin
            rd_addr = i[3:0];
            #0.5;
            v[127 - 8 * i -: 8] = rd_data;
        end
    endtask

    task automatic load(input logic [127:0] pt, input logic [127:0] key);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            ld_we   = 1'b1;
            ld_addr = i[4:0];
            ld_data = (i < 16) ? pt[127 - 8 * i -: 8] : key[127 - 8 * (i - 16) -: 8];
        end
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic run(input logic [127:0] pt, input logic [127:0] key, input bit noisy,
                       input string tag);
        logic [127:0] got;
        int cnt;
        bit seen, drop;
        load(pt, key);
        read_state(got);
        chk("R7 plaintext readback", got, pt);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        chk("R3 busy after start", 128'(busy), 128'd1);
        seen = 1'b0;
        drop = 1'b0;
        while (!seen && cnt < 1100) begin
            if (noisy) begin
                ld_we   = 1'($urandom);
                ld_addr = 5'($urandom);
                ld_data = 8'($urandom);
                start   = 1'($urandom);
            end
            @(negedge clk);
            cnt++;
            if (done) begin
                seen  = 1'b1;
                ld_we = 1'b0;
                start = 1'b0;
            end else if (busy !== 1'b1) begin
                drop = 1'b1;
            end
        end
        chk("R3 busy held until done", 128'(drop), 128'd0);
        chk("R5 done edge index", 128'(cnt), 128'd1035);
        chk("R5 busy low with done", 128'(busy), 128'd0);
        @(negedge clk);
        chk("R5 done single cycle", 128'(done), 128'd0);
        chk("R3 no restart", 128'(busy), 128'd0);
        read_state(got);
        chk(tag, got, aes_ref(pt, key));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            total++;
            bad++;
            $display("FAIL R5 watchdog got=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] v;
        void'($urandom(32'd90210));
        for (int a = 0; a < 256; a++) sb_tab[a] = m_sub(a[7:0]);
        chk("R4 reference model", aes_ref(128'h00112233445566778899aabbccddeeff,
                                          128'h000102030405060708090a0b0c0d0e0f),
            128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy reset", 128'(busy), 128'd0);
        chk("R1 done reset", 128'(done), 128'd0);
        read_state(v);
        chk("R1 state reset", v, 128'd0);

        run(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
            1'b0, "R4 standard vector");
        read_state(v);
        chk("R4 standard vector literal", v, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        run(128'd0, 128'd0, 1'b0, "R8 all-zero vector");
        read_state(v);
        chk("R8 all-zero literal", v, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
        run(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c,
            1'b1, "R6 noisy writes ignored");
        run({4{32'hffffffff}}, {4{32'hffffffff}}, 1'b0, "R4 all-ones vector");
        for (int n = 0; n < 6; n++) begin
            logic [127:0] p, k;
            p = {$urandom, $urandom, $urandom, $urandom};
            k = {$urandom, $urandom, $urandom, $urandom};
            run(p, k, n[0], n[0] ? "R6 random noisy" : "R4 random quiet");
        end
        // R2: a write while idle lands at the addressed plaintext byte
        @(negedge clk);
        ld_we = 1'b1; ld_addr = 5'd9; ld_data = 8'h5a;
        @(negedge clk);
        ld_we = 1'b0;
        rd_addr = 4'd9;
        #0.5;
        chk("R2 idle load write", 128'(rd_data), 128'h5a);

        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule